// File: doc/BRIEF.md
# Host Endpoint FIFO Bridge

This block is the master side of a USB device controller that runs its endpoints as plain external FIFOs. It owns one shared 16-bit FIFO data bus, a 2-bit endpoint address, a read strobe, a write strobe and a drive enable for the bus. Two flags come back from the device controller. One says the host-to-device endpoint has no data. The other says the device-to-host endpoint cannot take more data.

In one direction the bridge reads 16-bit command words from the host-to-device endpoint and hands each one to the scan sequencer as a single-cycle valid pulse. In the other direction it accepts filtered pixel words from the capture block into a small internal queue and writes them into the device-to-host endpoint. That endpoint ships its 512-byte bulk packets (256 bus words) without help from this block. Reads win over writes, so a command never waits behind a spectrum transfer. The bus is turned around through setup states, so the address is settled before any strobe and the bridge never drives the bus in the cycle after a read.

The bus sequencer has five named states:
- `S_IDLE`: parked, bus released.
- `S_RSETUP`: address moved to the host-to-device endpoint, bus released.
- `S_READ`: read strobes issued.
- `S_WSETUP`: address moved to the device-to-host endpoint, bus still released.
- `S_WRITE`: bus driven, write strobes issued.

The transitions are:
- `S_IDLE` goes to `S_READ` when commands are waiting and the address already selects the host-to-device endpoint. It goes to `S_RSETUP` when commands are waiting and the address selects the other endpoint.
- Otherwise `S_IDLE` goes to `S_WRITE` when a buffered word can be sent and the address already selects the device-to-host endpoint. It goes to `S_WSETUP` when a word can be sent and the address selects the other endpoint.
- `S_RSETUP` always goes to `S_READ`.
- `S_READ` stays in `S_READ` while commands remain. When they run out it goes to `S_WSETUP` if a word can be sent, and to `S_IDLE` if not.
- `S_WSETUP` goes to `S_RSETUP` if commands appear. Otherwise it goes to `S_WRITE`.
- `S_WRITE` goes to `S_RSETUP` if commands appear. Otherwise it goes to `S_IDLE` when the queue is empty, and stays in `S_WRITE` otherwise. It also stays, without strobing, while the device-to-host endpoint is full.

Top module: `usbf_bridge`

## Requirements
- R1: While reset is low and in the first cycle after it, `usb_rd`, `usb_wr`, `usb_oe` and `cmd_valid` are low, `pix_ready` is high and `usb_addr` is 2'b00.
- R2: `usb_rd` is never high in a cycle in which `usb_out_empty` is high.
- R3: `usb_wr` is never high in a cycle in which `usb_in_full` is high.
- R4: Reads have priority: `usb_wr` is high only in cycles in which `usb_out_empty` is high.
- R5: `usb_addr` is 2'b00 (host-to-device endpoint) in every read-strobe cycle and 2'b10 (device-to-host endpoint) in every write-strobe cycle, and in each case it held the same value in the previous cycle.
- R6: `usb_oe` is high only while `usb_addr` is 2'b10, is high in every write-strobe cycle, and is low in the cycle after any read strobe.
- R7: Every read strobe yields `cmd_valid` high in the next cycle, with `cmd_data` equal to the word on `usb_din` in the strobe cycle. `cmd_valid` is low in any cycle that does not follow a read strobe.
- R8: Accepted pixel words are written to the bus exactly once each, in arrival order, with the word on `usb_dout` during its write strobe.
- R9: `pix_ready` is high exactly when fewer than `PIX_DEPTH` (8) words are buffered. A word offered while `pix_ready` is low is not taken.
- R10: Once writing has begun, a word is written on every cycle in which the host-to-device endpoint stays empty, the device-to-host endpoint is not full, and buffered words remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Pixel word offered by the capture block |
| pix_data | input | 16 | Pixel word |
| pix_ready | output | 1 | Pixel queue can accept a word |
| cmd_valid | output | 1 | One-cycle pulse: new command word |
| cmd_data | output | 16 | Last command word read from the host |
| usb_out_empty | input | 1 | Host-to-device endpoint holds no data |
| usb_in_full | input | 1 | Device-to-host endpoint cannot accept data |
| usb_rd | output | 1 | Read strobe; word consumed at the clock edge |
| usb_wr | output | 1 | Write strobe; word committed at the clock edge |
| usb_oe | output | 1 | Bridge drives the shared data bus |
| usb_addr | output | 2 | Endpoint select: 2'b00 host-to-device, 2'b10 device-to-host |
| usb_din | input | 16 | Data bus as seen from the device controller |
| usb_dout | output | 16 | Data bus value driven when `usb_oe` is high |

## Verification
The strobes are combinational in the current state and the current flags. They are therefore due in the same cycle as the flag values that allow them, and the bench samples them one time unit after driving those flags on the falling edge. A command appears on `cmd_valid`/`cmd_data` exactly one cycle after its read strobe. `pix_ready` reflects the queue count as it stands after the last rising edge. The reference queues in the bench are therefore updated only after each sample, so each expectation lines up with the edge that commits it.

// File: rtl/usbf_bridge_pkg.sv
package usbf_bridge_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RSETUP,
        S_READ,
        S_WSETUP,
        S_WRITE
    } bus_state_t;

endpackage

// File: rtl/usbf_pix_fifo.sv
module usbf_pix_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         in_ready,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         not_empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr, wr_ptr_n, rd_ptr_n;
    logic [CW-1:0] count;
    logic          push, pop_ok;

    assign in_ready  = (count < CW'(DEPTH));
    assign not_empty = (count != '0);
    assign push      = in_valid && in_ready;
    assign pop_ok    = pop && not_empty;
    assign head      = mem[rd_ptr];

    // Pointer advance: natural wrap for power-of-two depths, compare otherwise
    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
            assign wr_ptr_n = wr_ptr + 1'b1;
            assign rd_ptr_n = rd_ptr + 1'b1;
        end else begin : g_any
            assign wr_ptr_n = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            assign rd_ptr_n = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)   wr_ptr <= wr_ptr_n;
            if (pop_ok) rd_ptr <= rd_ptr_n;
            unique case ({push, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/usbf_cmd_capture.sv
module usbf_cmd_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe,
    input  logic [W-1:0] bus_in,
    output logic         cmd_valid,
    output logic [W-1:0] cmd_data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_data  <= '0;
        end else begin
            cmd_valid <= strobe;
            if (strobe) begin
                cmd_data <= bus_in;
            end
        end
    end

endmodule

// File: rtl/usbf_bus_fsm.sv
module usbf_bus_fsm
    import usbf_bridge_pkg::*;
#(
    parameter int                ADDR_W   = 2,
    parameter logic [ADDR_W-1:0] ADDR_OUT = 2'b00,
    parameter logic [ADDR_W-1:0] ADDR_IN  = 2'b10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              out_empty,
    input  logic              in_full,
    input  logic              have_word,
    output logic              rd,
    output logic              wr,
    output logic              oe,
    output logic [ADDR_W-1:0] addr
);
    bus_state_t        state_q, state_n;
    logic [ADDR_W-1:0] addr_q, addr_n;
    logic              can_write;

    assign can_write = have_word && !in_full;

    // Next-state decision
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (!out_empty) begin
                    state_n = (addr_q == ADDR_OUT) ? S_READ : S_RSETUP;
                end else if (can_write) begin
                    state_n = (addr_q == ADDR_IN) ? S_WRITE : S_WSETUP;
                end
            end
            S_RSETUP: state_n = S_READ;
            S_READ: begin
                if (out_empty) begin
                    state_n = can_write ? S_WSETUP : S_IDLE;
                end
            end
            S_WSETUP: state_n = out_empty ? S_WRITE : S_RSETUP;
            S_WRITE: begin
                if (!out_empty) begin
                    state_n = S_RSETUP;
                end else if (!have_word) begin
                    state_n = S_IDLE;
                end
            end
            default: state_n = S_IDLE;
        endcase
    end

    // Address follows the state being entered, so it settles one cycle early
    always_comb begin
        unique case (state_n)
            S_RSETUP, S_READ:  addr_n = ADDR_OUT;
            S_WSETUP, S_WRITE: addr_n = ADDR_IN;
            default:           addr_n = addr_q;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            addr_q  <= ADDR_OUT;
        end else begin
            state_q <= state_n;
            addr_q  <= addr_n;
        end
    end

    // Outputs: strobes gated by the live flags
    always_comb begin
        rd   = (state_q == S_READ) && !out_empty;
        wr   = (state_q == S_WRITE) && can_write && out_empty;
        oe   = (state_q == S_WRITE);
        addr = addr_q;
    end

endmodule

// File: rtl/usbf_bridge.sv
module usbf_bridge #(
    parameter int                DW          = 16,
    parameter int                PIX_DEPTH   = 8,
    parameter int                ADDR_W      = 2,
    parameter logic [ADDR_W-1:0] EP_OUT_ADDR = 2'b00,
    parameter logic [ADDR_W-1:0] EP_IN_ADDR  = 2'b10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid,
    input  logic [DW-1:0]     pix_data,
    output logic              pix_ready,
    output logic              cmd_valid,
    output logic [DW-1:0]     cmd_data,
    input  logic              usb_out_empty,
    input  logic              usb_in_full,
    output logic              usb_rd,
    output logic              usb_wr,
    output logic              usb_oe,
    output logic [ADDR_W-1:0] usb_addr,
    input  logic [DW-1:0]     usb_din,
    output logic [DW-1:0]     usb_dout
);
    logic have_word;

    usbf_pix_fifo #(
        .W     (DW),
        .DEPTH (PIX_DEPTH)
    ) u_pix (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (pix_valid),
        .in_data   (pix_data),
        .in_ready  (pix_ready),
        .pop       (usb_wr),
        .head      (usb_dout),
        .not_empty (have_word)
    );

    usbf_bus_fsm #(
        .ADDR_W   (ADDR_W),
        .ADDR_OUT (EP_OUT_ADDR),
        .ADDR_IN  (EP_IN_ADDR)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .out_empty (usb_out_empty),
        .in_full   (usb_in_full),
        .have_word (have_word),
        .rd        (usb_rd),
        .wr        (usb_wr),
        .oe        (usb_oe),
        .addr      (usb_addr)
    );

    usbf_cmd_capture #(
        .W (DW)
    ) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (usb_rd),
        .bus_in    (usb_din),
        .cmd_valid (cmd_valid),
        .cmd_data  (cmd_data)
    );

endmodule

// File: rtl/usbf_bridge_chk.sv
module usbf_bridge_chk #(
    parameter int                DW          = 16,
    parameter int                ADDR_W      = 2,
    parameter logic [ADDR_W-1:0] EP_OUT_ADDR = 2'b00,
    parameter logic [ADDR_W-1:0] EP_IN_ADDR  = 2'b10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              usb_out_empty,
    input logic              usb_in_full,
    input logic              usb_rd,
    input logic              usb_wr,
    input logic              usb_oe,
    input logic [ADDR_W-1:0] usb_addr,
    input logic [DW-1:0]     usb_din,
    input logic              cmd_valid,
    input logic [DW-1:0]     cmd_data
);
    a_r2_no_read_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        usb_rd |-> !usb_out_empty);

    a_r3_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        usb_wr |-> !usb_in_full);

    a_r4_read_priority: assert property (@(posedge clk) disable iff (!rst_n)
        usb_wr |-> usb_out_empty);

    a_r5_read_addr_settled: assert property (@(posedge clk) disable iff (!rst_n)
        usb_rd |-> (usb_addr == EP_OUT_ADDR) && $stable(usb_addr));

    a_r5_write_addr_settled: assert property (@(posedge clk) disable iff (!rst_n)
        usb_wr |-> (usb_addr == EP_IN_ADDR) && $stable(usb_addr));

    a_r6_drive_only_on_in: assert property (@(posedge clk) disable iff (!rst_n)
        usb_oe |-> (usb_addr == EP_IN_ADDR));

    a_r6_release_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        usb_rd |=> !usb_oe);

    a_r6_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        usb_wr |-> usb_oe);

    a_r7_cmd_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        usb_rd |=> cmd_valid && (cmd_data == $past(usb_din)));

    a_r7_no_spurious_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        !usb_rd |=> !cmd_valid);

endmodule

bind usbf_bridge usbf_bridge_chk #(
    .DW          (DW),
    .ADDR_W      (ADDR_W),
    .EP_OUT_ADDR (EP_OUT_ADDR),
    .EP_IN_ADDR  (EP_IN_ADDR)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .usb_out_empty (usb_out_empty),
    .usb_in_full   (usb_in_full),
    .usb_rd        (usb_rd),
    .usb_wr        (usb_wr),
    .usb_oe        (usb_oe),
    .usb_addr      (usb_addr),
    .usb_din       (usb_din),
    .cmd_valid     (cmd_valid),
    .cmd_data      (cmd_data)
);

// File: tb/tb_usbf_bridge.sv
module tb_usbf_bridge;
    localparam int DW    = 16;
    localparam int DEPTH = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pix_valid = 1'b0;
    logic [DW-1:0] pix_data = '0;
    logic          pix_ready;
    logic          cmd_valid;
    logic [DW-1:0] cmd_data;
    logic          usb_out_empty = 1'b1;
    logic          usb_in_full = 1'b0;
    logic          usb_rd, usb_wr, usb_oe;
    logic [1:0]    usb_addr;
    logic [DW-1:0] usb_din = '0;
    logic [DW-1:0] usb_dout;

    usbf_bridge #(.DW(DW), .PIX_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
        .cmd_valid(cmd_valid), .cmd_data(cmd_data),
        .usb_out_empty(usb_out_empty), .usb_in_full(usb_in_full),
        .usb_rd(usb_rd), .usb_wr(usb_wr), .usb_oe(usb_oe), .usb_addr(usb_addr),
        .usb_din(usb_din), .usb_dout(usb_dout)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    logic [DW-1:0] host_q[$];
    logic [DW-1:0] pix_q[$];
    bit            pix_en = 1'b0;
    bit            force_full = 1'b0;
    logic [DW-1:0] pix_next = 16'h1000;
    bit            prev_rd = 1'b0;
    bit            prev_wr = 1'b0;
    bit            prev_empty = 1'b1;
    logic [DW-1:0] prev_din = '0;
    logic [1:0]    prev_addr = 2'b00;
    int            cmd_sent = 0;
    int            cmd_seen = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [DW-1:0] w);
        host_q.push_back(w);
        cmd_sent++;
    endtask

    // One cycle: drive on the falling edge, sample 1 time unit later,
    // then advance the model for the coming rising edge.
    task automatic step();
        @(negedge clk);
        usb_out_empty = (host_q.size() == 0);
        usb_din       = (host_q.size() != 0) ? host_q[0] : 16'h0000;
        usb_in_full   = force_full;
        pix_valid     = pix_en;
        pix_data      = pix_next;
        #1;
        // R7: command one cycle after its strobe
        if (prev_rd) begin
            chk(cmd_valid == 1'b1, "R7", "cmd_valid after read", int'(cmd_valid), 1);
            chk(cmd_data == prev_din, "R7", "cmd_data", int'(cmd_data), int'(prev_din));
            chk(usb_oe == 1'b0, "R6", "oe after read", int'(usb_oe), 0);
            cmd_seen++;
        end else begin
            chk(cmd_valid == 1'b0, "R7", "spurious cmd_valid", int'(cmd_valid), 0);
        end
        if (usb_rd) begin
            chk(!usb_out_empty, "R2", "read while empty", int'(usb_rd), 0);
            chk(usb_addr == 2'b00 && prev_addr == 2'b00, "R5", "read addr",
                int'({prev_addr, usb_addr}), 0);
        end
        if (usb_wr) begin
            chk(!usb_in_full, "R3", "write while full", int'(usb_wr), 0);
            chk(usb_out_empty, "R4", "write while command pending", int'(usb_wr), 0);
            chk(usb_addr == 2'b10 && prev_addr == 2'b10, "R5", "write addr",
                int'({prev_addr, usb_addr}), 'ha);
            chk(usb_oe, "R6", "oe on write", int'(usb_oe), 1);
            chk(pix_q.size() != 0 && usb_dout == pix_q[0], "R8", "write data",
                int'(usb_dout), (pix_q.size() != 0) ? int'(pix_q[0]) : -1);
        end
        if (usb_oe) begin
            chk(usb_addr == 2'b10, "R6", "oe with addr", int'(usb_addr), 2);
        end
        if (prev_wr && prev_empty && usb_out_empty && !usb_in_full && pix_q.size() != 0) begin
            chk(usb_wr, "R10", "back-to-back write", int'(usb_wr), 1);
        end
        chk(pix_ready == (pix_q.size() < DEPTH), "R9", "pix_ready vs fill",
            int'(pix_ready), int'(pix_q.size() < DEPTH));
        // Advance the model
        prev_rd    = usb_rd;
        prev_din   = usb_din;
        prev_wr    = usb_wr;
        prev_empty = usb_out_empty;
        prev_addr  = usb_addr;
        if (usb_rd && host_q.size() != 0) void'(host_q.pop_front());
        if (usb_wr && pix_q.size() != 0) void'(pix_q.pop_front());
        if (pix_valid && pix_ready) begin
            pix_q.push_back(pix_data);
            pix_next = pix_next + 16'h0001;
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        chk({usb_rd, usb_wr, usb_oe, cmd_valid} == 4'b0, "R1", "strobes in reset",
            int'({usb_rd, usb_wr, usb_oe, cmd_valid}), 0);
        chk(pix_ready == 1'b1, "R1", "pix_ready in reset", int'(pix_ready), 1);
        chk(usb_addr == 2'b00, "R1", "addr in reset", int'(usb_addr), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk({usb_rd, usb_wr, usb_oe, cmd_valid} == 4'b0, "R1", "strobes after reset",
            int'({usb_rd, usb_wr, usb_oe, cmd_valid}), 0);

        // Commands only (R2, R7)
        send_cmd(16'hA001);
        send_cmd(16'h0320);
        send_cmd(16'hFFFF);
        repeat (10) step();
        chk(host_q.size() == 0, "R2", "host words consumed", host_q.size(), 0);

        // Pixel streaming (R8, R10)
        pix_en = 1'b1;
        repeat (40) step();
        pix_en = 1'b0;
        repeat (12) step();
        chk(pix_q.size() == 0, "R8", "stream drained", pix_q.size(), 0);

        // Endpoint full: queue fills, upstream stalls (R3, R9)
        force_full = 1'b1;
        pix_en = 1'b1;
        repeat (20) step();
        chk(pix_q.size() == DEPTH, "R9", "queue full count", pix_q.size(), DEPTH);
        chk(pix_ready == 1'b0, "R9", "stalled when full", int'(pix_ready), 0);
        force_full = 1'b0;
        repeat (15) step();

        // Mixed traffic: commands arrive mid-burst, endpoint full toggles (R4, R5, R6)
        for (int i = 0; i < 90; i++) begin
            force_full = (i % 7 == 3);
            if (i % 13 == 5) send_cmd(16'h5000 + 16'(i));
            if (i % 29 == 11) begin
                send_cmd(16'h7100 + 16'(i));
                send_cmd(16'h7200 + 16'(i));
            end
            step();
        end

        // Drain everything
        pix_en = 1'b0;
        force_full = 1'b0;
        repeat (30) step();
        chk(pix_q.size() == 0, "R8", "all pixels written", pix_q.size(), 0);
        chk(cmd_seen == cmd_sent, "R7", "all commands delivered", cmd_seen, cmd_sent);

        done = 1'b1;
        finish_run();
    end

endmodule